// File: doc/BRIEF.md
# Offline Controller Fault Supervisor

This block decides, cycle by cycle, whether the gate driver of an offline switching controller may switch. It also decides whether the high-voltage startup current source is on. All of its inputs are digital flags from analog comparators. Each hysteresis band arrives as a pair of flags: one flag sets a condition and the other clears it. The block has two supply phases. In the startup phase the current source charges the supply. In the run phase the gate may switch, as long as no protection condition is active.

Four protections are independent of each other:
- **Overload:** a latch that is released only after the supply has dropped out twice.
- **Supply over-voltage:** clears itself at the next supply turn-on.
- **Line brownout and line over-voltage:** each is a set/clear latch.
- **Feedback shutdown:** acts directly and holds no state.

All flags pass through a two-flop synchronizer before any of this logic sees them. The overload qualification window is a cycle count set by a parameter.

Top module: `offline_fault_supervisor`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters the startup phase and clears all latches, timers and the dropout divider. After reset, `hv_src_en_o`=1 and `gate_en_o`=0.
- R2: In the startup phase, `hv_src_en_o`=1 and `gate_en_o`=0. A high `vdd_on_i` moves the block to the run phase. There `hv_src_en_o`=0 and, with no fault active, `gate_en_o`=1.
- R3: In the run phase, a high `vdd_off_i` returns the block to the startup phase, with `hv_src_en_o`=1 and `gate_en_o`=0.
- R4: An overload latch is set when `fb_olp_i` has been high for OLP_CYCLES consecutive synchronized cycles in the run phase. A shorter run does not set it, and any low cycle restarts the count.
- R5: While the overload latch is set, the gate stays off through the first supply dropout and the next turn-on. The second dropout releases the latch, and the turn-on after that switches again.
- R6: A high `vdd_ovp_i` turns the gate off until the next supply turn-on, which clears the condition.
- R7: A high `line_low_i` holds the gate off, even across a supply turn-on. Only a high `line_good_i` releases the hold; the return of `line_low_i` to low does not.
- R8: A high `line_high_i` holds the gate off. Only a high `line_safe_i` releases the hold; the return of `line_high_i` to low does not.
- R9: While `fb_shdn_i` is high, the gate is off. Removing it restores switching, with no latched state.
- R10: Changes caused by the supply phase appear at the outputs on the third rising edge after an input changes. A change on `fb_shdn_i` appears at `gate_en_o` on the second rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vdd_on_i | input | 1 | Supply above turn-on level |
| vdd_off_i | input | 1 | Supply below turn-off level |
| vdd_ovp_i | input | 1 | Supply above over-voltage level |
| fb_olp_i | input | 1 | Feedback above overload level |
| fb_shdn_i | input | 1 | Feedback pulled below shutdown level |
| line_low_i | input | 1 | Line below brownout-off level |
| line_good_i | input | 1 | Line above brownout-on level |
| line_high_i | input | 1 | Line above over-voltage trip level |
| line_safe_i | input | 1 | Line below over-voltage release level |
| gate_en_o | output | 1 | Gate switching allowed |
| hv_src_en_o | output | 1 | Startup current source enabled |

## Verification
The assertions assume that the two flags of any hysteresis pair are never high in the same cycle. These pairs are turn-on and turn-off, brownout set and clear, and line over-voltage set and clear. The assertions also assume that every flag level lasts at least one full clock cycle, so the synchronizer passes it through unchanged. The stimulus drives each flag only at falling edges, pulses the set and clear flags of a pair one at a time, and returns each to low before the other partner is raised. The overload sweep holds the feedback flag for every length from one cycle up to two past the window, each on a freshly reset block.

// File: rtl/fs_pkg.sv
package fs_pkg;

  typedef enum logic {PH_START = 1'b0, PH_RUN = 1'b1} phase_t;

  localparam int F_VON   = 0;
  localparam int F_VOFF  = 1;
  localparam int F_VOVP  = 2;
  localparam int F_OLP   = 3;
  localparam int F_SHDN  = 4;
  localparam int F_LLO   = 5;
  localparam int F_LOK   = 6;
  localparam int F_LHI   = 7;
  localparam int F_LSAFE = 8;
  localparam int NFLAG   = 9;

  // Gate permission: run phase and every protection clear
  function automatic logic gate_allow(input logic running, input logic olp_lat,
                                      input logic ovp_pend, input logic bo_hold,
                                      input logic lovp_hold, input logic shdn);
    return running & ~olp_lat & ~ovp_pend & ~bo_hold & ~lovp_hold & ~shdn;
  endfunction

  // Next value of the one-bit dropout divider and release strobe
  function automatic logic [1:0] divide_step(input logic div_q, input logic dropout);
    // {release, next_div}
    if (!dropout) return {1'b0, div_q};
    return div_q ? 2'b10 : 2'b01;
  endfunction

endpackage

// File: rtl/fs_sync.sv
module fs_sync #(
  parameter int W      = 9,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/fs_olp_timer.sv
module fs_olp_timer #(
  parameter int HOLD = 1500000
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic level,
  output logic trip
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] cnt;

  assign trip = enable && level && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !enable || !level || trip) cnt <= '0;
    else                                   cnt <= cnt + 1'b1;
  end

  // R4: a trip needs the level already high in the previous cycle
  trip_needs_history_chk: assert property (@(posedge clk) disable iff (rst)
    trip |-> $past(level));
endmodule

// File: rtl/fs_hyst_latch.sv
module fs_hyst_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end
endmodule

// File: rtl/offline_fault_supervisor.sv
module offline_fault_supervisor #(
  parameter int OLP_CYCLES  = 1500000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic vdd_on_i,
  input  logic vdd_off_i,
  input  logic vdd_ovp_i,
  input  logic fb_olp_i,
  input  logic fb_shdn_i,
  input  logic line_low_i,
  input  logic line_good_i,
  input  logic line_high_i,
  input  logic line_safe_i,
  output logic gate_en_o,
  output logic hv_src_en_o
);
  import fs_pkg::*;

  logic [NFLAG-1:0] raw, s;

  always_comb begin
    raw          = '0;
    raw[F_VON]   = vdd_on_i;
    raw[F_VOFF]  = vdd_off_i;
    raw[F_VOVP]  = vdd_ovp_i;
    raw[F_OLP]   = fb_olp_i;
    raw[F_SHDN]  = fb_shdn_i;
    raw[F_LLO]   = line_low_i;
    raw[F_LOK]   = line_good_i;
    raw[F_LHI]   = line_high_i;
    raw[F_LSAFE] = line_safe_i;
  end

  fs_sync #(.W(NFLAG), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(s));

  phase_t phase;
  logic   turn_on_evt, turn_off_evt;
  logic   olp_trip, olp_latch, uv_div;
  logic   ovp_pend, bo_hold, lovp_hold;
  logic [1:0] div_nx;

  assign turn_on_evt  = (phase == PH_START) && s[F_VON];
  assign turn_off_evt = (phase == PH_RUN)   && s[F_VOFF];
  assign div_nx       = divide_step(uv_div, turn_off_evt);

  always_ff @(posedge clk) begin
    if (rst)               phase <= PH_START;
    else if (turn_on_evt)  phase <= PH_RUN;
    else if (turn_off_evt) phase <= PH_START;
  end

  fs_olp_timer #(.HOLD(OLP_CYCLES)) u_olp (
    .clk(clk), .rst(rst),
    .enable((phase == PH_RUN) && !olp_latch),
    .level(s[F_OLP]), .trip(olp_trip));

  always_ff @(posedge clk) begin
    if (rst) begin
      olp_latch <= 1'b0;
      uv_div    <= 1'b0;
    end else if (olp_trip) begin
      olp_latch <= 1'b1;
      uv_div    <= 1'b0;
    end else if (olp_latch) begin
      uv_div <= div_nx[0];
      if (div_nx[1]) olp_latch <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              ovp_pend <= 1'b0;
    else if (turn_on_evt) ovp_pend <= 1'b0;
    else if (s[F_VOVP])   ovp_pend <= 1'b1;
  end

  fs_hyst_latch u_brownout (
    .clk(clk), .rst(rst), .set_i(s[F_LLO]), .clr_i(s[F_LOK]), .q(bo_hold));

  fs_hyst_latch u_line_ovp (
    .clk(clk), .rst(rst), .set_i(s[F_LHI]), .clr_i(s[F_LSAFE]), .q(lovp_hold));

  assign gate_en_o   = gate_allow(phase == PH_RUN, olp_latch, ovp_pend,
                                  bo_hold, lovp_hold, s[F_SHDN]);
  assign hv_src_en_o = (phase == PH_START);

  // R4
  olp_latch_sets_chk: assert property (@(posedge clk) disable iff (rst)
    olp_trip |=> olp_latch);
  // R5
  olp_release_on_dropout_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(olp_latch) |-> $past(turn_off_evt));
  // R6
  ovp_clears_on_turn_on_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ovp_pend) |-> $past(turn_on_evt));
  // R3
  dropout_restarts_source_chk: assert property (@(posedge clk) disable iff (rst)
    turn_off_evt |=> (hv_src_en_o && !gate_en_o));
  // R7
  brownout_blocks_gate_chk: assert property (@(posedge clk) disable iff (rst)
    gate_en_o |-> !$past(s[F_LLO]));
  // R8
  line_ovp_blocks_gate_chk: assert property (@(posedge clk) disable iff (rst)
    gate_en_o |-> !$past(s[F_LHI]));
endmodule

// File: tb/tb_offline_fault_supervisor.sv
module tb_offline_fault_supervisor;
  localparam int HOLD = 8;
  localparam int VON = 0, VOFF = 1, VOVP = 2, OLP = 3, SHDN = 4,
                 LLO = 5, LOK = 6, LHI = 7, LSAFE = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [8:0] fl = '0;
  logic gate, hv;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  offline_fault_supervisor #(.OLP_CYCLES(HOLD), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst),
    .vdd_on_i(fl[VON]), .vdd_off_i(fl[VOFF]), .vdd_ovp_i(fl[VOVP]),
    .fb_olp_i(fl[OLP]), .fb_shdn_i(fl[SHDN]),
    .line_low_i(fl[LLO]), .line_good_i(fl[LOK]),
    .line_high_i(fl[LHI]), .line_safe_i(fl[LSAFE]),
    .gate_en_o(gate), .hv_src_en_o(hv));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0b exp=%0b", tag, got, exp);
    end
  endtask

  task automatic pulse(input int idx);
    fl[idx] = 1'b1; step(1); fl[idx] = 1'b0; step(4);
  endtask

  task automatic do_reset();
    fl = '0; rst = 1'b1; step(3); rst = 1'b0; step(1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1 reset state
    do_reset();
    chk("R1 hv after reset", hv, 1'b1);
    chk("R1 gate after reset", gate, 1'b0);

    // R2 and R10 turn-on latency: outputs move at the third rising edge
    fl[VON] = 1'b1; step(2);
    chk("R10 hv before third edge", hv, 1'b1);
    step(1);
    chk("R10 hv at third edge", hv, 1'b0);
    chk("R2 gate after turn-on", gate, 1'b1);
    fl[VON] = 1'b0; step(3);

    // R9 and R10: shutdown acts at the second edge, releases without state
    fl[SHDN] = 1'b1; step(1);
    chk("R10 shdn not yet", gate, 1'b1);
    step(1);
    chk("R9 shdn blocks gate", gate, 1'b0);
    fl[SHDN] = 1'b0; step(3);
    chk("R9 shdn released", gate, 1'b1);

    // R3 turn-off
    pulse(VOFF);
    chk("R3 hv after dropout", hv, 1'b1);
    chk("R3 gate after dropout", gate, 1'b0);

    // R6 supply over-voltage until next turn-on
    pulse(VON);
    pulse(VOVP);
    chk("R6 ovp blocks gate", gate, 1'b0);
    pulse(VOFF);
    pulse(VON);
    chk("R6 ovp cleared by turn-on", gate, 1'b1);

    // R7 brownout set/clear
    pulse(LLO);
    chk("R7 brownout blocks", gate, 1'b0);
    step(5);
    chk("R7 low flag gone, still held", gate, 1'b0);
    pulse(VOFF);
    pulse(VON);
    chk("R7 held across turn-on", gate, 1'b0);
    pulse(LOK);
    chk("R7 released by good flag", gate, 1'b1);

    // R8 line over-voltage set/clear
    pulse(LHI);
    chk("R8 line ovp blocks", gate, 1'b0);
    step(5);
    chk("R8 trip flag gone, still held", gate, 1'b0);
    pulse(LSAFE);
    chk("R8 released by safe flag", gate, 1'b1);

    // R4 overload window sweep: each length on a fresh block
    for (int k = 1; k <= HOLD + 2; k++) begin
      do_reset();
      pulse(VON);
      fl[OLP] = 1'b1; step(k); fl[OLP] = 1'b0; step(4);
      chk($sformatf("R4 overload length %0d", k), gate, (k < HOLD) ? 1'b1 : 1'b0);
    end

    // R4 interrupted run restarts the count
    do_reset();
    pulse(VON);
    fl[OLP] = 1'b1; step(HOLD - 1); fl[OLP] = 1'b0; step(1);
    fl[OLP] = 1'b1; step(HOLD - 1); fl[OLP] = 1'b0; step(4);
    chk("R4 interrupted no trip", gate, 1'b1);

    // R5 latch released only on second dropout
    fl[OLP] = 1'b1; step(HOLD + 1); fl[OLP] = 1'b0; step(4);
    chk("R5 latched off", gate, 1'b0);
    pulse(VOFF);
    chk("R5 first dropout hv on", hv, 1'b1);
    pulse(VON);
    chk("R5 still latched after first cycle", gate, 1'b0);
    chk("R5 source off in run", hv, 1'b0);
    pulse(VOFF);
    pulse(VON);
    chk("R5 released after second dropout", gate, 1'b1);

    finish_run();
  end
endmodule